// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO Buffer

A first-in first-out buffer, 18 bits wide and 512 words deep. Its write and read ports each have their own clock, and the two clocks may be the same net or fully unrelated. Writes are qualified by an active-low write enable and reads by an active-low read enable. Both pointers cross between the clock domains as Gray codes through two-flop synchronizers. Full and half-full are computed on the write side. Empty is computed on the read side.

A static strap selects the read timing. In standard timing, each word reaches the output register only when a read is strobed. In fall-through timing, the head word is loaded into the output register without any strobe. A read enable then consumes it, and the next word follows it in.

Two of the status pins change meaning with the mode:

| Pin | Standard timing, low means | Fall-through timing, low means |
|-----|----------------------------|--------------------------------|
| `empty_or_n_o` | empty | a valid word is on the output |
| `full_ir_n_o` | full | space is available |

The output enable is modelled as a qualifier: when it is high, the data output reads as zero.

Top module: `dual_mode_fifo`

## Requirements
- R1: The array holds 512 words of 18 bits. In standard timing, after 512 accepted writes with no reads, `full_ir_n_o` is low.
- R2: A word is stored on a rising write-clock edge only when `wen_ni` is low and the buffer is not full. Writes offered while full are dropped and never appear at the output.
- R3: A word is removed on a rising read-clock edge only when `ren_ni` is low and a word is available. While `ren_ni` is high, the output data holds its previous value.
- R4: In standard timing, `empty_or_n_o` is low while no word is stored. A word written into an empty buffer does not change `dout_o` until a read is strobed.
- R5: In fall-through timing, a word written into an empty buffer appears on `dout_o` within 8 read-clock edges without any read enable. `empty_or_n_o` then goes low, meaning output ready.
- R6: Asserting `rst_ni` low clears both pointers and the output register to zero. After reset in standard timing, `empty_or_n_o`=0 and `full_ir_n_o`=1. After reset in fall-through timing, `empty_or_n_o`=1 and `full_ir_n_o`=0.
- R7: `half_n_o` is low exactly when more than 256 words are stored. It is high at 256 words and low at 257 words.
- R8: In fall-through timing, `full_ir_n_o` is an input-ready flag: low while space is available, high when no space is left. Capacity there is 513 words: the 512-word array plus the output register.
- R9: Words leave in the order they were written, with intact values, whether the clocks are tied or independent.
- R10: Each registered Gray pointer changes in at most one bit per clock edge of its own domain.
- R11: While `oe_ni` is high, `dout_o` reads 0. Lowering `oe_ni` again restores the held word.
- R12: With tied clocks and a stored count away from empty and full, a simultaneous read and write in the same cycle leaves the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwft_i | input | 1 | Timing strap: 0 standard, 1 fall-through |
| wen_ni | input | 1 | Write enable, active low |
| din_i | input | 18 | Write data |
| ren_ni | input | 1 | Read enable, active low |
| oe_ni | input | 1 | Output qualifier, active low |
| dout_o | output | 18 | Read data |
| empty_or_n_o | output | 1 | Empty (standard) or output-ready (fall-through), active low |
| full_ir_n_o | output | 1 | Full (standard) or input-ready (fall-through), active low |
| half_n_o | output | 1 | More than half full, active low |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:

- **Full boundary.** Extra writes at the 512th word must vanish. A design that wraps its write pointer would overwrite the oldest word and deliver a corrupted sequence.
- **Half-full boundary.** The flag is checked at 256 and at 257 stored words, to catch a comparison that is off by one.
- **Standard-timing empty case.** A design that pre-fetched the head word would show it on `dout_o` before the strobe.
- **Fall-through timing.** The bench checks the unprompted arrival of the head word, the inverted flag polarity, and the 513-word capacity. Flags left in standard polarity, or an output stage that fails to refill, would stall or drop a word.
- **Concurrent access.** Concurrent reads and writes under tied and unrelated clocks are compared word by word against a queue model. Pointer-crossing errors would then show up as repeated or lost words.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int unsigned DATA_W_DEF = 18;
  localparam int unsigned DEPTH_DEF  = 512;
  typedef enum logic {RD_STD = 1'b0, RD_FWFT = 1'b1} rd_mode_e;
endpackage

// File: rtl/dmf_ptr_sync.sv
module dmf_ptr_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dmf_ram.sv
module dmf_ram #(
  parameter int unsigned W     = 18,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/dmf_wr_ctrl.sv
module dmf_wr_ctrl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_ni,
  input  logic [AW:0]   rgray_sync_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          half_o
);
  localparam logic [AW:0] HALF = AW'(DEPTH / 2);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [AW:0] wbin_q, wgray_q, wbin_nxt, wgray_nxt, rbin_s, occ_nxt;
  logic        full_q, half_q;

  assign we_o      = !wen_ni && !full_q;
  assign wbin_nxt  = wbin_q + {{AW{1'b0}}, we_o};
  assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
  assign rbin_s    = g2b(rgray_sync_i);
  assign occ_nxt   = wbin_nxt - rbin_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wgray_nxt;
      // full: top two bits differ, the rest match
      full_q  <= wgray_nxt == {~rgray_sync_i[AW:AW-1], rgray_sync_i[AW-2:0]};
      half_q  <= occ_nxt > HALF;
    end
  end

  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;
  assign full_o  = full_q;
  assign half_o  = half_q;

  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> wbin_q == $past(wbin_q));
  assert_wgray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dmf_rd_ctrl.sv
module dmf_rd_ctrl #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW:0]   wgray_sync_i,
  output logic          pop_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o
);
  logic [AW:0] rbin_q, rgray_q, rbin_nxt, rgray_nxt;
  logic        empty_q;

  assign pop_o     = req_i && !empty_q;
  assign rbin_nxt  = rbin_q + {{AW{1'b0}}, pop_o};
  assign rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rgray_nxt;
      empty_q <= rgray_nxt == wgray_sync_i;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign empty_o = empty_q;

  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_q |=> rbin_q == $past(rbin_q));
  assert_rgray_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned DEPTH  = DEPTH_DEF,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              fwft_i,
  input  logic              wen_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ren_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] dout_o,
  output logic              empty_or_n_o,
  output logic              full_ir_n_o,
  output logic              half_n_o
);
  rd_mode_e          mode;
  logic              we, pop, rd_req, full, half, empty, valid_q;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] rdata;

  assign mode = rd_mode_e'(fwft_i);

  dmf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .wen_ni(wen_ni), .rgray_sync_i(rgray_s),
    .we_o(we), .waddr_o(waddr), .wgray_o(wgray), .full_o(full), .half_o(half)
  );

  dmf_ptr_sync #(.W(AW + 1)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray), .q_o(rgray_s)
  );

  dmf_ptr_sync #(.W(AW + 1)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray), .q_o(wgray_s)
  );

  // fall-through: refill the output stage whenever it is empty or being consumed
  assign rd_req = (mode == RD_FWFT) ? (!valid_q || !ren_ni) : !ren_ni;

  dmf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk_i(rclk_i), .rst_ni(rst_ni), .req_i(rd_req), .wgray_sync_i(wgray_s),
    .pop_o(pop), .raddr_o(raddr), .rgray_o(rgray), .empty_o(empty)
  );

  dmf_ram #(.W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(din_i),
    .rclk_i(rclk_i), .rst_ni(rst_ni), .re_i(pop), .raddr_i(raddr), .rdata_o(rdata)
  );

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= 1'b0;
    else if (pop)     valid_q <= 1'b1;
    else if (!ren_ni) valid_q <= 1'b0;
  end

  assign dout_o       = oe_ni ? '0 : rdata;
  assign empty_or_n_o = (mode == RD_FWFT) ? !valid_q : !empty;
  assign full_ir_n_o  = (mode == RD_FWFT) ? full : !full;
  assign half_n_o     = !half;

  assert_std_hold_R3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode == RD_STD && ren_ni) |=> $stable(rdata));
  assert_fwft_hold_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (mode == RD_FWFT && valid_q && ren_ni) |=> (valid_q && $stable(rdata)));
endmodule

// File: tb/sim_dual_mode_fifo.sv
module sim_dual_mode_fifo;
  logic wclk = 0, rclk_free = 0, tied = 0;
  logic rst_n = 0, fwft = 0, wen_n = 1, ren_n = 1, oe_n = 0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic efor_n, ffir_n, hf_n;
  logic rclk;
  int checks = 0, fails = 0, rd_count = 0;
  bit done = 0, pend = 0;
  logic [17:0] q[$];
  logic [17:0] exp_w;

  always #5 wclk = ~wclk;
  always #7 rclk_free = ~rclk_free;
  assign rclk = tied ? wclk : rclk_free;

  dual_mode_fifo u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .fwft_i(fwft), .wen_ni(wen_n),
    .din_i(din), .ren_ni(ren_n), .oe_ni(oe_n), .dout_o(dout),
    .empty_or_n_o(efor_n), .full_ir_n_o(ffir_n), .half_n_o(hf_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic bit can_write();
    return fwft ? (ffir_n == 1'b0) : (ffir_n == 1'b1);
  endfunction

  // reference model: push on accepted writes (R2)
  always @(posedge wclk) if (rst_n && !wen_n && can_write()) q.push_back(din);

  // reference model: pops and data comparison (R9)
  always @(posedge rclk) begin
    if (rst_n && !ren_n) begin
      if (fwft && efor_n == 1'b0) begin
        rd_count++;
        if (q.size() == 0) chk(0, "R9", 32'(dout), 0);
        else begin
          exp_w = q.pop_front();
          chk(dout == exp_w, "R9", 32'(dout), 32'(exp_w));
        end
      end else if (!fwft && efor_n == 1'b1) begin
        rd_count++;
        if (q.size() == 0) chk(0, "R3", 0, 1);
        else begin
          exp_w = q.pop_front();
          pend = 1;
        end
      end
    end
  end
  always @(negedge rclk) if (pend) begin
    chk(dout == exp_w, "R3", 32'(dout), 32'(exp_w));
    pend = 0;
  end

  task automatic do_reset(input bit mode, input bit tie);
    rst_n = 0; wen_n = 1; ren_n = 1; oe_n = 0;
    #20;
    fwft = mode; tied = tie;
    q.delete();
    #40;
    @(negedge wclk); rst_n = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic write_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge wclk); wen_n = 0; din = 18'($urandom);
    end
    @(negedge wclk); wen_n = 1;
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk); ren_n = 0;
    end
    @(negedge rclk); ren_n = 1;
  endtask

  task automatic idle_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic drain();
    int quiet = 0;
    for (int i = 0; i < 4000 && quiet < 12; i++) begin
      @(negedge rclk); ren_n = 0;
      if ((fwft && efor_n) || (!fwft && !efor_n)) quiet++; else quiet = 0;
    end
    @(negedge rclk); ren_n = 1;
    idle_r(2);
  endtask

  task automatic random_traffic(input int cycles);
    fork
      for (int i = 0; i < cycles; i++) begin
        @(negedge wclk); wen_n = ($urandom % 3) == 0; din = 18'($urandom);
      end
      for (int i = 0; i < cycles; i++) begin
        @(negedge rclk); ren_n = ($urandom % 2) == 0;
      end
    join
    @(negedge wclk); wen_n = 1;
    @(negedge rclk); ren_n = 1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [17:0] held;
    void'($urandom(32'd4242));

    // standard timing, independent clocks
    do_reset(0, 0);
    chk(efor_n == 0, "R6", efor_n, 0);
    chk(ffir_n == 1, "R6", ffir_n, 1);
    chk(hf_n == 1, "R6", hf_n, 1);
    chk(dout == 0, "R6", dout, 0);

    write_n(1);
    idle_r(8);
    chk(efor_n == 1, "R4", efor_n, 1);
    chk(dout == 0, "R4", dout, 0);
    read_n(1);
    idle_r(4);
    chk(efor_n == 0, "R4", efor_n, 0);

    // half and full boundaries
    write_n(256);
    repeat (3) @(negedge wclk);
    chk(hf_n == 1, "R7", hf_n, 1);
    write_n(1);
    repeat (3) @(negedge wclk);
    chk(hf_n == 0, "R7", hf_n, 0);
    write_n(255);
    repeat (3) @(negedge wclk);
    chk(ffir_n == 0, "R1", ffir_n, 0);
    write_n(4);
    repeat (3) @(negedge wclk);
    chk(ffir_n == 0, "R2", ffir_n, 0);
    rd_count = 0;
    drain();
    chk(rd_count == 512, "R2", rd_count, 512);
    chk(efor_n == 0, "R2", efor_n, 0);

    // output qualifier
    write_n(1);
    idle_r(8);
    read_n(1);
    idle_r(2);
    held = dout;
    oe_n = 1; #1;
    chk(dout == 0, "R11", dout, 0);
    oe_n = 0; #1;
    chk(dout == held, "R11", dout, held);

    random_traffic(3000);
    drain();
    chk(q.size() == 0, "R9", q.size(), 0);

    // tied clocks: concurrent read and write
    do_reset(0, 1);
    write_n(300);
    idle_r(6);
    chk(hf_n == 0, "R12", hf_n, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge wclk); wen_n = 0; ren_n = 0; din = 18'($urandom);
    end
    @(negedge wclk); wen_n = 1; ren_n = 1;
    idle_r(6);
    chk(hf_n == 0, "R12", hf_n, 0);
    rd_count = 0;
    drain();
    chk(rd_count == 300, "R12", rd_count, 300);
    random_traffic(2000);
    drain();
    chk(q.size() == 0, "R9", q.size(), 0);

    // fall-through timing
    do_reset(1, 0);
    chk(efor_n == 1, "R6", efor_n, 1);
    chk(ffir_n == 0, "R8", ffir_n, 0);
    write_n(1);
    held = q[0];
    idle_r(8);
    chk(efor_n == 0, "R5", efor_n, 0);
    chk(dout == held, "R5", dout, held);
    read_n(1);
    idle_r(4);
    chk(efor_n == 1, "R5", efor_n, 1);

    write_n(520);
    idle_r(8);
    chk(ffir_n == 1, "R8", ffir_n, 1);
    rd_count = 0;
    drain();
    chk(rd_count == 513, "R8", rd_count, 513);
    repeat (4) @(negedge wclk);
    chk(ffir_n == 0, "R8", ffir_n, 0);

    random_traffic(3000);
    drain();
    chk(q.size() == 0, "R9", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule